// File: doc/BRIEF.md
# BUSY-synchronized serial ADC receiver

This block collects conversion results from a converter that paces its own conversions and shifts each result out on a serial clock that it drives. The receiver is a clocked slave. It brings the converter's serial clock, serial data and select line into the system clock domain through two-flop synchronizers and finds their edges there. The converter's BUSY output drives the select line. A low-to-high edge on that line marks the end of a conversion.

After it is enabled, the receiver stays disarmed and ignores all serial traffic until it has seen one end-of-conversion edge. This keeps it from locking onto a word that is already half shifted out. Once armed, it samples serial data on each falling edge of the serial clock, which idles low. It assembles 12-bit words with the MSB first. Each completed word goes to a held output register together with a one-cycle valid strobe.

A select toggle that arrives while a word is partly received throws that word away and sends the receiver back to the disarmed state.

The controller has three states:
- ST_IDLE: disabled.
- ST_WAIT: enabled but disarmed.
- ST_RECV: armed and shifting.

It has four transitions:
- T_EN: ST_IDLE to ST_WAIT, taken when enable is high.
- T_SYNC: ST_WAIT to ST_RECV, taken on a synchronized select rise.
- T_ABORT: ST_RECV to ST_WAIT, taken on a select toggle with 1 to 11 bits held.
- T_DIS: any state to ST_IDLE, taken when enable is low.

Top module: `busy_sync_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `word_out` is 0, `word_valid` is 0 and `armed` is 0.
- R2: After enable goes high the receiver stays disarmed (`armed` = 0). Serial clock falling edges seen before the first select low-to-high edge produce no `word_valid`.
- R3: A low-to-high edge on `sel_in` while enabled and disarmed sets `armed` to 1. The edge is seen through a two-flop synchronizer, so `armed` rises within 4 system clocks of the edge.
- R4: While armed, one bit of `sdata_in` is taken on each falling edge of `sclk_in`. Rising edges take no bit. The first bit taken becomes bit 11 of the word and the twelfth becomes bit 0.
- R5: After the twelfth bit, `word_out` takes the assembled word and `word_valid` is high for exactly one cycle. `word_out` changes only in a cycle where `word_valid` is high, and otherwise holds its value.
- R6: A change of `sel_in` while 1 to 11 bits of a word are held discards those bits and clears `armed`. No word appears until a new select low-to-high edge has been seen, and the next word then starts from an empty shift register.
- R7: With `enable` low, `armed` is 0 from the next cycle, no `word_valid` is produced and `word_out` is kept. Re-enabling requires a new select low-to-high edge.
- R8: While armed, successive words are received back to back without re-synchronizing. A select toggle when no bits are held leaves `armed` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable |
| sclk_in | input | 1 | Serial clock from the converter, idles low |
| sdata_in | input | 1 | Serial data, valid at the serial clock falling edge |
| sel_in | input | 1 | Select line driven by the converter's BUSY |
| word_out | output | 12 | Last received word |
| word_valid | output | 1 | One-cycle strobe when `word_out` is updated |
| armed | output | 1 | High while synchronized and receiving |

## Verification
The assertions check several rules on every cycle:
- the valid strobe lasts a single cycle and appears only while armed;
- arming follows a synchronized select rise;
- disabling clears `armed` on the next cycle;
- `word_out` changes only together with the strobe;
- the bit counter never reaches the word length.

Other behaviour can only be shown by the bench's scenarios: the bit order, rejection of traffic before synchronization, the discard and re-arm after a mid-word select toggle, tolerance of toggles between words, and the need for a fresh edge after re-enabling.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dout_prev
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_prev <= '0;
        else        dout_prev <= stage[STAGES-1];
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
    parameter int WORD_W = 12,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_next,
    output logic [CNT_W-1:0]  cnt,
    output logic              last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;

    assign word_next = {shreg[WORD_W-2:0], bit_in};
    assign last      = shift_en && (cnt == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_en) begin
            shreg <= word_next;
            cnt   <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/busy_sync_rx.sv
module busy_sync_rx #(
    parameter int WORD_W      = 12,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              sel_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              armed
);
    import rx_pkg::*;

    rx_state_t state_q, state_d;

    logic [2:0] pins_s, pins_p;
    logic sclk_s, sdata_s, sel_s, sclk_p, sel_p;
    logic sclk_fall, sel_rise, sel_toggle;
    logic abort, clear, shift_en, last;
    logic [WORD_W-1:0] word_next;
    logic [CNT_W-1:0]  bit_cnt;

    rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       ({sel_in, sdata_in, sclk_in}),
        .dout      (pins_s),
        .dout_prev (pins_p)
    );

    assign sclk_s  = pins_s[0];
    assign sdata_s = pins_s[1];
    assign sel_s   = pins_s[2];
    assign sclk_p  = pins_p[0];
    assign sel_p   = pins_p[2];

    assign sclk_fall  = sclk_p & ~sclk_s;
    assign sel_rise   = ~sel_p & sel_s;
    assign sel_toggle = sel_p ^ sel_s;

    assign abort    = (state_q == ST_RECV) && sel_toggle && (bit_cnt != '0);
    assign clear    = (state_q != ST_RECV) || abort || !enable;
    assign shift_en = (state_q == ST_RECV) && enable && sclk_fall && !abort;

    rx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .shift_en  (shift_en),
        .bit_in    (sdata_s),
        .word_next (word_next),
        .cnt       (bit_cnt),
        .last      (last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)    state_d = ST_WAIT;
            ST_WAIT: if (!enable)   state_d = ST_IDLE;
                     else if (sel_rise) state_d = ST_RECV;
            ST_RECV: if (!enable)   state_d = ST_IDLE;
                     else if (abort) state_d = ST_WAIT;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= last;
            if (last) word_out <= word_next;
        end
    end

    assign armed = (state_q == ST_RECV);
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
    parameter int WORD_W = 12,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [WORD_W-1:0] word_out,
    input logic              word_valid,
    input logic              armed,
    input logic              sel_rise,
    input logic [CNT_W-1:0]  bit_cnt
);
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> word_valid);

    assert_valid_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(armed));

    assert_arm_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(sel_rise) && $past(enable)));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!armed && !word_valid));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(WORD_W));
endmodule

bind busy_sync_rx rx_checker #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .word_out   (word_out),
    .word_valid (word_valid),
    .armed      (armed),
    .sel_rise   (sel_rise),
    .bit_cnt    (bit_cnt)
);

// File: tb/sim_busy_sync_rx.sv
`timescale 1ns/1ps
module sim_busy_sync_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic sclk_in = 1'b0;
    logic sdata_in = 1'b0;
    logic sel_in = 1'b0;
    logic [11:0] word_out;
    logic word_valid;
    logic armed;

    always #5 clk = ~clk;

    busy_sync_rx u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sclk_in(sclk_in),
        .sdata_in(sdata_in), .sel_in(sel_in), .word_out(word_out),
        .word_valid(word_valid), .armed(armed)
    );

    int checks = 0;
    int fails  = 0;
    int n_valid = 0;
    bit done = 1'b0;
    logic [11:0] got_word = '0;

    localparam int NVEC = 6;
    localparam logic [11:0] VEC [NVEC] = '{12'hA5C, 12'hFFF, 12'h000,
                                          12'h801, 12'h001, 12'h3C3};

    always @(negedge clk) begin
        if (word_valid) begin
            n_valid  <= n_valid + 1;
            got_word <= word_out;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b;
        wait_cyc(4);
        sclk_in = 1'b1;
        wait_cyc(4);
        sclk_in = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_bits(input logic [11:0] w, input int n);
        for (int i = 11; i > 11 - n; i--) send_bit(w[i]);
        wait_cyc(4);
    endtask

    task automatic set_sel(input logic v);
        sel_in = v;
        wait_cyc(6);
    endtask

    initial begin
        int base;
        logic [11:0] held;
        wait_cyc(3);
        // R1 during reset
        check("R1 word_out in reset", 32'(word_out), 0);
        check("R1 valid in reset", 32'(word_valid), 0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 armed after reset", 32'(armed), 0);
        check("R1 word_out after reset", 32'(word_out), 0);

        // R2 traffic before sync edge ignored
        enable = 1'b1;
        wait_cyc(4);
        base = n_valid;
        send_bits(12'h5A5, 12);
        check("R2 no word before sync", 32'(n_valid - base), 0);
        check("R2 still disarmed", 32'(armed), 0);

        // R3 select rise arms
        set_sel(1'b1);
        check("R3 armed after rise", 32'(armed), 1);

        // R4 R5 R8 table walk, with select toggles between words
        for (int k = 0; k < NVEC; k++) begin
            base = n_valid;
            send_bits(VEC[k], 12);
            check("R5 one valid per word", 32'(n_valid - base), 1);
            check("R4 word value msb first", 32'(got_word), 32'(VEC[k]));
            wait_cyc(10);
            check("R5 word_out held", 32'(word_out), 32'(VEC[k]));
            set_sel(1'b0);
            set_sel(1'b1);
            check("R8 stays armed across idle toggle", 32'(armed), 1);
        end

        // R6 mid-word select toggle discards and disarms
        send_bits(12'hFFF, 5);
        set_sel(1'b0);
        check("R6 disarmed after mid-word toggle", 32'(armed), 0);
        base = n_valid;
        send_bits(12'h123, 12);
        check("R6 no word while disarmed", 32'(n_valid - base), 0);
        set_sel(1'b1);
        check("R6 re-armed", 32'(armed), 1);
        base = n_valid;
        send_bits(12'h2B4, 12);
        check("R6 one word after re-arm", 32'(n_valid - base), 1);
        check("R6 clean word after discard", 32'(got_word), 32'h2B4);

        // R7 disable
        enable = 1'b0;
        wait_cyc(2);
        check("R7 disarmed when disabled", 32'(armed), 0);
        held = word_out;
        base = n_valid;
        send_bits(12'h777, 12);
        check("R7 no word while disabled", 32'(n_valid - base), 0);
        check("R7 word_out kept", 32'(word_out), 32'(held));
        enable = 1'b1;
        wait_cyc(4);
        base = n_valid;
        send_bits(12'h666, 12);
        check("R7 needs new edge after enable", 32'(n_valid - base), 0);
        set_sel(1'b0);
        set_sel(1'b1);
        base = n_valid;
        send_bits(12'h9E1, 12);
        check("R7 word after re-sync", 32'(n_valid - base), 1);
        check("R7 word value after re-sync", 32'(got_word), 32'h9E1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule